// File: doc/BRIEF.md
# Programmable Event Counter Slice

This block is a single general-purpose performance counter for a processor core. Software programs a 32-bit event-select word. The word enables counting, chooses which privilege levels count, and can turn the raw per-cycle event tally into a thresholded, inverted or edge-detected condition. Each cycle the core supplies three inputs: a flag that says the core's event decoder matched the programmed event code and unit mask, the number of occurrences in that cycle, and whether the core runs in user or kernel mode. A global enable from the shared control block must also be high before anything is counted.

The counter is `CNT_W` bits wide, at least 33. A software write loads the low 32 bits of the data and copies bit 31 into every bit above it. This lets software preload a small negative value, so that the counter wraps after a chosen number of events. On a wrap the block raises a one-cycle overflow pulse. It raises an interrupt-request pulse alongside it only when the interrupt bit of the select word is set.

Top module: `perf_evt_counter`

## Requirements
- R1: After reset the select word reads 0, the counter reads 0, and both pulses are low.
- R2: A cycle adds to the counter only when all of these are high: select bit 22 (enable), `glb_en` and `ev_match`. With the threshold field (bits 31:24) at zero, such a cycle adds `ev_count`.
- R3: A user-mode cycle (`priv_user`=1) counts only if bit 16 is set. A kernel-mode cycle (`priv_user`=0) counts only if bit 17 is set.
- R4: While bit 22 is clear and no counter write happens, the counter holds its value.
- R5: With a non-zero threshold and bit 23 clear, a qualified cycle adds exactly 1 when `ev_count` is at or above the threshold, and 0 otherwise.
- R6: With a non-zero threshold and bit 23 (invert) set, a qualified cycle adds 1 when `ev_count` is below the threshold.
- R7: With a non-zero threshold and bit 18 (edge) set, the counter adds 1 only in a cycle where the qualified threshold condition is true and was false in the cycle before.
- R8: A counter write loads `cnt_wdata` and copies bit 31 into all upper bits. A write takes priority over counting in the same cycle.
- R9: When an addition carries out of the top counter bit, `ovf_pulse` is high for exactly the next cycle, together with the wrapped count. Preloading 1-N and counting N events leaves the counter at 1.
- R10: `irq_pulse` rises with `ovf_pulse` only when select bit 20 was set when the wrap occurred. It is never high without `ovf_pulse`.
- R11: A select write is readable on `sel_q` from the next cycle and takes effect on counting from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the event-select word |
| sel_wdata | input | 32 | Event-select write data |
| cnt_wr | input | 1 | Write strobe for the counter |
| cnt_wdata | input | 32 | Counter write data, sign-extended from bit 31 |
| ev_match | input | 1 | The core's decoder matched the selected event this cycle |
| ev_count | input | EVC_W | Occurrences of the event this cycle |
| priv_user | input | 1 | 1 = user mode, 0 = kernel mode |
| glb_en | input | 1 | Global enable for this counter |
| sel_q | output | 32 | Current event-select word |
| count_q | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse after a wrap |
| irq_pulse | output | 1 | One-cycle interrupt request after a wrap when bit 20 is set |

## Verification
All state that matters is visible on the ports one cycle after the edge that sets it, because `count_q`, `sel_q` and both pulses come straight from registers. A wrong qualification term or threshold compare therefore shows up as a wrong count in the cycle right after the stimulus. A stale or wrongly updated edge-history bit is different: it shows only in the cycle after it goes wrong, as one missing or one extra increment, so the bench drives alternating above- and below-threshold patterns. A wrong sign extension appears in the upper counter bits right after a write. A missing carry appears as a missing pulse in the cycle that shows the wrapped value.

// File: rtl/perf_evt_pkg.sv
package perf_evt_pkg;
   // field positions of the event-select word
   localparam int SB_USR  = 16;
   localparam int SB_KRN  = 17;
   localparam int SB_EDGE = 18;
   localparam int SB_INT  = 20;
   localparam int SB_EN   = 22;
   localparam int SB_INV  = 23;
   localparam int SB_THR  = 24;
   localparam int THR_W   = 8;

   typedef struct packed {
      logic             en;
      logic             usr;
      logic             krn;
      logic             edge_md;
      logic             inv;
      logic             irq_en;
      logic [THR_W-1:0] thr;
   } sel_ctl_t;

   function automatic sel_ctl_t unpack_sel(input logic [31:0] w);
      sel_ctl_t c;
      c.en      = w[SB_EN];
      c.usr     = w[SB_USR];
      c.krn     = w[SB_KRN];
      c.edge_md = w[SB_EDGE];
      c.inv     = w[SB_INV];
      c.irq_en  = w[SB_INT];
      c.thr     = w[SB_THR +: THR_W];
      return c;
   endfunction
endpackage

// File: rtl/perf_evt_selreg.sv
module perf_evt_selreg
   import perf_evt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic [31:0] word_q,
   output sel_ctl_t    ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (wr) word_q <= wdata;
   end

   assign ctl = unpack_sel(word_q);
endmodule

// File: rtl/perf_evt_qual.sv
module perf_evt_qual
   import perf_evt_pkg::*;
#(
   parameter int EVC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sel_ctl_t         ctl,
   input  logic             ev_match,
   input  logic [EVC_W-1:0] ev_count,
   input  logic             priv_user,
   input  logic             glb_en,
   output logic [EVC_W-1:0] inc
);
   localparam int CMP_W = (EVC_W > THR_W) ? EVC_W : THR_W;

   logic             priv_ok, qual, thr_on, thr_hit, thr_q, prev_q;
   logic [CMP_W-1:0] cnt_x, thr_x;

   generate
      if (EVC_W >= THR_W) begin : g_wide_evc
         assign cnt_x = ev_count;
         assign thr_x = CMP_W'(ctl.thr);
      end else begin : g_narrow_evc
         assign cnt_x = CMP_W'(ev_count);
         assign thr_x = ctl.thr;
      end
   endgenerate

   assign priv_ok = priv_user ? ctl.usr : ctl.krn;
   assign qual    = ctl.en & glb_en & ev_match & priv_ok;
   assign thr_on  = (ctl.thr != '0);
   assign thr_hit = ctl.inv ? (cnt_x < thr_x) : (cnt_x >= thr_x);
   assign thr_q   = qual & thr_on & thr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= thr_q;
   end

   always_comb begin
      if (!thr_on)          inc = qual ? ev_count : '0;
      else if (ctl.edge_md) inc = EVC_W'(thr_q & ~prev_q);
      else                  inc = EVC_W'(thr_q);
   end

   // R5
   thr_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.thr != '0) |-> (inc <= EVC_W'(1)));
endmodule

// File: rtl/perf_evt_accum.sv
module perf_evt_accum #(
   parameter int CNT_W = 48,
   parameter int EVC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [31:0]      wdata,
   input  logic [EVC_W-1:0] inc,
   input  logic             irq_en,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_q,
   output logic             irq_q
);
   localparam int UP_W = CNT_W - 32;

   logic [CNT_W:0] sum;
   assign sum = {1'b0, count_q} + (CNT_W+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else if (wr) begin
         count_q <= {{UP_W{wdata[31]}}, wdata};
         ovf_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         count_q <= sum[CNT_W-1:0];
         ovf_q   <= sum[CNT_W];
         irq_q   <= sum[CNT_W] & irq_en;
      end
   end

   // R8
   sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (count_q[CNT_W-1:32] == {UP_W{$past(wdata[31])}}));
   // R9
   wrap_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (count_q < CNT_W'(1 << EVC_W)));
endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter
   import perf_evt_pkg::*;
#(
   parameter int CNT_W = 48,
   parameter int EVC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [31:0]      sel_wdata,
   input  logic             cnt_wr,
   input  logic [31:0]      cnt_wdata,
   input  logic             ev_match,
   input  logic [EVC_W-1:0] ev_count,
   input  logic             priv_user,
   input  logic             glb_en,
   output logic [31:0]      sel_q,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_pulse,
   output logic             irq_pulse
);
   generate
      if (CNT_W < 33)     begin : g_bad_cnt_w  $error("CNT_W must be at least 33"); end
      if (EVC_W < 1)      begin : g_bad_evc_lo $error("EVC_W must be at least 1");  end
      if (EVC_W >= CNT_W) begin : g_bad_evc_hi $error("EVC_W must be below CNT_W"); end
   endgenerate

   sel_ctl_t         ctl;
   logic [EVC_W-1:0] inc;

   perf_evt_selreg u_sel (
      .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata),
      .word_q(sel_q), .ctl(ctl));

   perf_evt_qual #(.EVC_W(EVC_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .ev_match(ev_match),
      .ev_count(ev_count), .priv_user(priv_user), .glb_en(glb_en), .inc(inc));

   perf_evt_accum #(.CNT_W(CNT_W), .EVC_W(EVC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(cnt_wdata), .inc(inc),
      .irq_en(ctl.irq_en), .count_q(count_q), .ovf_q(ovf_pulse), .irq_q(irq_pulse));

   // R4
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q[SB_EN] && !cnt_wr) |=> $stable(count_q));
   // R10
   irq_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ovf_pulse);
endmodule

// File: tb/perf_evt_counter_bench.sv
module perf_evt_counter_bench;
   localparam int  W = 48;
   localparam int  E = 4;
   localparam time TCLK = 10ns;

   logic clk = 0, rst_n = 0;
   logic sel_wr = 0, cnt_wr = 0, ev_match = 0, priv_user = 0, glb_en = 0;
   logic [31:0] sel_wdata = 0, cnt_wdata = 0;
   logic [E-1:0] ev_count = 0;
   logic [31:0] sel_q;
   logic [W-1:0] count_q;
   logic ovf_pulse, irq_pulse;

   always #(TCLK/2) clk = ~clk;

   perf_evt_counter #(.CNT_W(W), .EVC_W(E)) u_perf_evt_counter (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ev_match(ev_match),
      .ev_count(ev_count), .priv_user(priv_user), .glb_en(glb_en),
      .sel_q(sel_q), .count_q(count_q), .ovf_pulse(ovf_pulse), .irq_pulse(irq_pulse));

   typedef struct {
      logic [W-1:0] cnt;
      logic         ovf;
      logic         irq;
      logic [31:0]  sel;
      string        tag;
   } exp_t;

   exp_t q[$];
   int total = 0, bad = 0;
   logic [W-1:0] m_cnt = 0;
   logic [31:0]  m_sel = 0;
   logic         m_prev = 0;

   // event-select words used below
   localparam logic [31:0] EN = 32'h0040_0000, USR = 32'h0001_0000, KRN = 32'h0002_0000;
   localparam logic [31:0] EDG = 32'h0004_0000, INTB = 32'h0010_0000, INV = 32'h0080_0000;
   localparam logic [31:0] INSTR = 32'h0000_00C0;

   task automatic cyc(input logic sw, input logic [31:0] sd, input logic cw,
                      input logic [31:0] cd, input logic m, input logic [E-1:0] ec,
                      input logic u, input logic g, input string tag);
      logic q_ok, thr;
      logic [7:0] cm;
      logic [E-1:0] inc;
      logic [W:0] s;
      exp_t x;
      @(negedge clk);
      sel_wr = sw; sel_wdata = sd; cnt_wr = cw; cnt_wdata = cd;
      ev_match = m; ev_count = ec; priv_user = u; glb_en = g;
      q_ok = m_sel[22] & g & m & (u ? m_sel[16] : m_sel[17]);
      cm   = m_sel[31:24];
      thr  = m_sel[23] ? ({4'b0, ec} < cm) : ({4'b0, ec} >= cm);
      if (cm == 0) inc = q_ok ? ec : '0;
      else if (m_sel[18]) inc = E'(q_ok & thr & ~m_prev);
      else inc = E'(q_ok & thr);
      m_prev = (cm != 0) & q_ok & thr;
      if (cw) begin
         m_cnt = {{(W-32){cd[31]}}, cd}; x.ovf = 0; x.irq = 0;
      end else begin
         s = {1'b0, m_cnt} + (W+1)'(inc);
         m_cnt = s[W-1:0]; x.ovf = s[W]; x.irq = s[W] & m_sel[20];
      end
      if (sw) m_sel = sd;
      x.cnt = m_cnt; x.sel = m_sel; x.tag = tag;
      @(posedge clk);
      q.push_back(x);
   endtask

   // monitor: compare one expected item per cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         total++;
         if (count_q !== x.cnt || ovf_pulse !== x.ovf || irq_pulse !== x.irq || sel_q !== x.sel) begin
            bad++;
            $display("FAIL %s: cnt=%h ovf=%b irq=%b sel=%h expected cnt=%h ovf=%b irq=%b sel=%h",
                     x.tag, count_q, ovf_pulse, irq_pulse, sel_q, x.cnt, x.ovf, x.irq, x.sel);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (count_q !== '0 || sel_q !== '0 || ovf_pulse || irq_pulse) begin
         bad++;
         $display("FAIL R1: cnt=%h sel=%h ovf=%b irq=%b expected all zero", count_q, sel_q, ovf_pulse, irq_pulse);
      end
      rst_n = 1;
      // R11 select write, counting starts next cycle
      cyc(1, EN|USR|KRN|INSTR, 0, 0, 1, 1, 0, 1, "R11");
      // R2 plain counting, multi-occurrence
      cyc(0, 0, 0, 0, 1, 1, 0, 1, "R2");
      cyc(0, 0, 0, 0, 1, 3, 1, 1, "R2");
      cyc(0, 0, 0, 0, 1, 15, 0, 1, "R2");
      cyc(0, 0, 0, 0, 1, 5, 0, 0, "R2 global off");
      cyc(0, 0, 0, 0, 0, 5, 0, 1, "R2 no match");
      // R3 privilege filter
      cyc(1, EN|USR|INSTR, 0, 0, 1, 2, 0, 1, "R3");
      cyc(0, 0, 0, 0, 1, 2, 0, 1, "R3 kernel dropped");
      cyc(0, 0, 0, 0, 1, 2, 1, 1, "R3 user counted");
      cyc(1, EN|KRN|INSTR, 0, 0, 1, 2, 1, 1, "R3");
      cyc(0, 0, 0, 0, 1, 2, 1, 1, "R3 user dropped");
      cyc(0, 0, 0, 0, 1, 2, 0, 1, "R3 kernel counted");
      // R4 freeze
      cyc(1, USR|KRN|INSTR, 0, 0, 1, 4, 0, 1, "R4");
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 4, 0, 1, "R4 frozen");
      // R5 threshold 2
      cyc(1, 32'h0200_0000|EN|USR|KRN|INSTR, 0, 0, 1, 1, 0, 1, "R5");
      cyc(0, 0, 0, 0, 1, 1, 0, 1, "R5 below");
      cyc(0, 0, 0, 0, 1, 2, 0, 1, "R5 at");
      cyc(0, 0, 0, 0, 1, 9, 0, 1, "R5 above");
      // R6 invert
      cyc(1, 32'h0200_0000|INV|EN|USR|KRN|INSTR, 0, 0, 1, 1, 0, 1, "R6");
      cyc(0, 0, 0, 0, 1, 0, 0, 1, "R6 below");
      cyc(0, 0, 0, 0, 1, 2, 0, 1, "R6 at");
      cyc(0, 0, 0, 0, 1, 1, 0, 1, "R6 below");
      // R7 edge
      cyc(1, 32'h0200_0000|EDG|EN|USR|KRN|INSTR, 0, 0, 1, 0, 0, 1, "R7");
      cyc(0, 0, 0, 0, 1, 3, 0, 1, "R7 rise");
      cyc(0, 0, 0, 0, 1, 3, 0, 1, "R7 held");
      cyc(0, 0, 0, 0, 1, 0, 0, 1, "R7 fall");
      cyc(0, 0, 0, 0, 1, 4, 0, 1, "R7 rise");
      cyc(0, 0, 0, 0, 1, 4, 0, 1, "R7 held");
      // R8 sign extension and write priority
      cyc(1, EN|USR|KRN|INSTR, 1, 32'hF345_6789, 1, 3, 0, 1, "R8 neg");
      cyc(0, 0, 1, 32'h0000_1234, 1, 3, 0, 1, "R8 pos");
      cyc(0, 0, 0, 0, 1, 1, 0, 1, "R8 count after");
      // R9 preload 1-5, five events, no interrupt bit
      cyc(0, 0, 1, 32'hFFFF_FFFC, 0, 0, 0, 1, "R9 preload");
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 1, 0, 1, "R9 wrap");
      // R10 same with interrupt bit
      cyc(1, INTB|EN|USR|KRN|INSTR, 1, 32'hFFFF_FFFC, 0, 0, 0, 1, "R10 preload");
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 1, 0, 1, "R10 wrap");
      // R9 multi-count wrap landing on 1
      cyc(0, 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 1, "R9 preload");
      cyc(0, 0, 0, 0, 1, 3, 0, 1, "R9 wrap by 3");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, "R9 pulse ends");
      @(negedge clk);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule